// File: doc/BRIEF.md
# SAR ADC Control and Conversion Sequencer

This block is the register front end and conversion sequencer for a small successive-approximation converter with two sampling engines. The auxiliary engine converts one of two auxiliary inputs. The battery engine converts the battery input in one of two reference ranges. Software sets an engine's start bit in the enable register to begin a conversion. That bit then serves as the engine's busy flag, and the block clears it by itself once the result has been stored in the engine's data register.

The analog side is modelled as a 12-bit sample input per source. The selected sample is held at the start edge and is delivered after a fixed number of clock ticks. Writing 0xFF to the control register while the block is fully idle starts a settling period. During that period every start request is refused.

Accesses may be a byte, a halfword or a word. Only the low byte of the enable, config and control registers has any function, so a write changes them only when that byte is one of the bytes written. Read data is returned combinationally for the current address.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Registers are word-aligned at these offsets: enable 0x00, config 0x04, control 0x08, status 0x0C, battery data 0x1C, auxiliary data 0x20. Reads of any other offset return zero. Enable reads as {pd[7], bat_busy[1], aux_busy[0]}, config reads as {low_range[4], aux_sel[1:0]}, control returns its stored byte, and status bit 0 reads 1 while settling is in progress.
- R2: Writing enable bit 0 starts the auxiliary engine and writing bit 1 starts the battery engine. The started bit reads 1 for exactly CONV_CYCLES cycles and then clears by itself.
- R3: The data register is loaded in the same cycle that its busy bit clears. The value loaded is the sample held at the start edge. The result occupies bits [11:0] and the upper bits read zero.
- R4: Config aux_sel 01 selects auxiliary input 0 and 10 selects auxiliary input 1. With 00 or 11, an auxiliary start is ignored.
- R5: When config bit 4 is 1, the battery result is the full 12-bit sample. When it is 0, the result is the sample shifted right by 12-BAT_HI_BITS.
- R6: A start written to an engine that is already busy is ignored and does not restart it. Writing 0 to a busy bit does not cancel the conversion.
- R7: Enable bit 7 is a read/write power-down bit. A start is refused if bit 7 was set before the write or is set by the write itself.
- R8: Writing 0xFF to control while the enable register reads zero sets status bit 0 for SETTLE_CYCLES cycles, and starts are refused during that time. Writing 0xFF while the enable register is nonzero starts no settling.
- R9: A write changes the enable, config or control register only when byte lane 0 is written: any word write, a halfword write at offset 0, or a byte write at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when 1, read when 0 |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data, byte lane 0 in [7:0] |
| rdata_o | output | 32 | Read data for addr_i |
| aux0_sample_i | input | 12 | Auxiliary input 0 sample |
| aux1_sample_i | input | 12 | Auxiliary input 1 sample |
| bat_sample_i | input | 12 | Battery input sample |

## Verification
The bench builds the block with CONV_CYCLES=6, SETTLE_CYCLES=40 and BAT_HI_BITS=10. With a short conversion, the bench can rewrite the enable register several times while one conversion is still running. With a short settling period, the bench can watch the settling window open and close and then see a start accepted right after it ends. With a 10-bit high range, the battery result shifts right by two bits, so the two ranges give visibly different values.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned RES_W = 12;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  // word index = addr[5:2]
  localparam logic [3:0] IDX_EN   = 4'h0;
  localparam logic [3:0] IDX_CFG  = 4'h1;
  localparam logic [3:0] IDX_CTL  = 4'h2;
  localparam logic [3:0] IDX_STAT = 4'h3;
  localparam logic [3:0] IDX_BDAT = 4'h7;
  localparam logic [3:0] IDX_ADAT = 4'h8;

  function automatic logic low_lane_hit(logic [1:0] size, logic [1:0] off);
    case (size)
      SZ_WORD: return 1'b1;
      SZ_HALF: return !off[1];
      SZ_BYTE: return off == 2'd0;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sar_conv_engine.sv
module sar_conv_engine #(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned RES_W       = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES > 1 ? CONV_CYCLES : 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      hold_q   <= '0;
      result_o <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
      hold_q <= sample_i;
    end else if (busy_o) begin
      if (cnt_q == LAST) begin
        busy_o   <= 1'b0;
        result_o <= hold_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_result_at_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(result_o));
endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trigger_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (trigger_i)         cnt_q <= CNT_W'(SETTLE_CYCLES);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = cnt_q != '0;

  assert_settle_armed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(trigger_i));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES   = 16,
  parameter int unsigned SETTLE_CYCLES = 100000,
  parameter int unsigned BAT_HI_BITS   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [11:0] aux0_sample_i,
  input  logic [11:0] aux1_sample_i,
  input  logic [11:0] bat_sample_i
);
  localparam int unsigned BAT_SHIFT = RES_W - BAT_HI_BITS;
  localparam int unsigned N_ENG = 2; // 0 aux, 1 battery

  logic [3:0]       idx;
  logic             wr_lo, en_wr, cfg_wr, ctl_wr;
  logic             pd_q, low_q;
  logic [1:0]       sel_q;
  logic [7:0]       ctl_q;
  logic             settling, settle_trig;
  logic [N_ENG-1:0] busy, start;
  logic [RES_W-1:0] smp [N_ENG];
  logic [RES_W-1:0] res [N_ENG];
  logic             aux_sel_ok, start_ok;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[31:8];

  assign idx    = addr_i[5:2];
  assign wr_lo  = req_i && we_i && low_lane_hit(size_i, addr_i[1:0]);
  assign en_wr  = wr_lo && (idx == IDX_EN);
  assign cfg_wr = wr_lo && (idx == IDX_CFG);
  assign ctl_wr = wr_lo && (idx == IDX_CTL);

  assign aux_sel_ok  = (sel_q == 2'b01) || (sel_q == 2'b10);
  assign start_ok    = en_wr && !pd_q && !wdata_i[7] && !settling;
  assign settle_trig = ctl_wr && (wdata_i[7:0] == 8'hFF) && !pd_q && (busy == '0);

  always_comb begin
    start[0] = start_ok && wdata_i[0] && aux_sel_ok && !busy[0];
    start[1] = start_ok && wdata_i[1] && !busy[1];
  end

  // source held by the engine at its start edge
  assign smp[0] = sel_q[1] ? aux1_sample_i : aux0_sample_i;
  assign smp[1] = low_q ? bat_sample_i : (bat_sample_i >> BAT_SHIFT);

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    sar_conv_engine #(
      .CONV_CYCLES(CONV_CYCLES),
      .RES_W      (RES_W)
    ) u_eng (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[e]),
      .sample_i(smp[e]),
      .busy_o  (busy[e]),
      .result_o(res[e])
    );
  end

  sar_settle_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trigger_i(settle_trig),
    .active_o (settling)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q  <= 1'b0;
      sel_q <= 2'b00;
      low_q <= 1'b0;
      ctl_q <= 8'h00;
    end else begin
      if (en_wr)  pd_q <= wdata_i[7];
      if (cfg_wr) begin
        sel_q <= wdata_i[1:0];
        low_q <= wdata_i[4];
      end
      if (ctl_wr) ctl_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_EN:   rdata_o = {24'd0, pd_q, 5'd0, busy};
      IDX_CFG:  rdata_o = {27'd0, low_q, 2'd0, sel_q};
      IDX_CTL:  rdata_o = {24'd0, ctl_q};
      IDX_STAT: rdata_o = {31'd0, settling};
      IDX_BDAT: rdata_o = {{(32-RES_W){1'b0}}, res[1]};
      IDX_ADAT: rdata_o = {{(32-RES_W){1'b0}}, res[0]};
      default:  rdata_o = '0;
    endcase
  end

  assert_pd_blocks_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy[0]) || $rose(busy[1])) |-> !$past(pd_q) && !pd_q);

  assert_settle_blocks_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settling |=> !($rose(busy[0]) || $rose(busy[1])));

  assert_aux_sel_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy[0]) |-> ($past(sel_q) == 2'b01 || $past(sel_q) == 2'b10));
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int CONV   = 6;
  localparam int SETTLE = 40;
  localparam int HI     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [5:0]  addr = 6'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [11:0] aux0 = 12'd0, aux1 = 12'd0, bat = 12'd0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  sar_adc_ctrl #(.CONV_CYCLES(CONV), .SETTLE_CYCLES(SETTLE), .BAT_HI_BITS(HI)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .aux0_sample_i(aux0), .aux1_sample_i(aux1), .bat_sample_i(bat));

  // behavioural reference
  int m_ab, m_bb, m_ac, m_bc, m_ah, m_bh, m_ad, m_bd;
  int m_pd, m_sel, m_low, m_ctl, m_set;

  function automatic int mread(int a);
    case ((a >> 2) & 15)
      0: return (m_pd << 7) | (m_bb << 1) | m_ab;
      1: return (m_low << 4) | m_sel;
      2: return m_ctl;
      3: return (m_set != 0) ? 1 : 0;
      7: return m_bd;
      8: return m_ad;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab = 0; m_bb = 0; m_ac = 0; m_bc = 0; m_ah = 0; m_bh = 0; m_ad = 0; m_bd = 0;
      m_pd = 0; m_sel = 0; m_low = 0; m_ctl = 0; m_set = 0;
    end else begin
      int o_ab, o_bb, o_pd, o_set, o_sel, o_low, w, ridx;
      bit lane0;
      o_ab = m_ab; o_bb = m_bb; o_pd = m_pd; o_set = m_set; o_sel = m_sel; o_low = m_low;
      w = int'(wdata[7:0]);
      ridx = int'(addr) >> 2;
      lane0 = req && we && (size == 2'd2 || (size == 2'd1 && addr[1] == 1'b0) ||
                            (size == 2'd0 && addr[1:0] == 2'd0));
      if (m_ab != 0) begin
        if (m_ac == CONV - 1) begin m_ab = 0; m_ad = m_ah; end else m_ac++;
      end
      if (m_bb != 0) begin
        if (m_bc == CONV - 1) begin m_bb = 0; m_bd = m_bh; end else m_bc++;
      end
      if (m_set > 0) m_set--;
      if (lane0 && ridx == 0) begin
        m_pd = (w >> 7) & 1;
        if (o_pd == 0 && m_pd == 0 && o_set == 0) begin
          if ((w & 1) != 0 && o_ab == 0 && (o_sel == 1 || o_sel == 2)) begin
            m_ab = 1; m_ac = 0; m_ah = (o_sel == 1) ? int'(aux0) : int'(aux1);
          end
          if ((w & 2) != 0 && o_bb == 0) begin
            m_bb = 1; m_bc = 0; m_bh = o_low != 0 ? int'(bat) : (int'(bat) >> (12 - HI));
          end
        end
      end
      if (lane0 && ridx == 1) begin m_sel = w & 3; m_low = (w >> 4) & 1; end
      if (lane0 && ridx == 2) begin
        m_ctl = w;
        if (w == 255 && o_ab == 0 && o_bb == 0 && o_pd == 0) m_set = SETTLE;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every clock
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) chk({cur_tag, " (model)"}, int'(rdata), mread(int'(addr)));
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(logic [5:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      addr = 6'h00;
      #1;
      if (rdata[1:0] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int v, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    rd(6'h00, v); chk("R1 enable after reset", v, 0);
    rd(6'h20, v); chk("R1 aux data after reset", v, 0);

    // R2/R3: aux0 conversion, busy length, sample held at start
    cur_tag = "R2";
    wr(6'h04, 2'd2, 32'h0000_0001);
    aux0 = 12'hABC;
    wr(6'h00, 2'd0, 32'h01);
    aux0 = 12'h123;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      addr = 6'h00; #1;
      if (rdata[0]) cnt++; else break;
      @(negedge clk);
    end
    chk("R2 busy cycles", cnt, CONV);
    rd(6'h20, v); chk("R3 aux data held sample", v, 32'hABC);

    // R4: second aux input, then invalid select
    cur_tag = "R4";
    wr(6'h04, 2'd2, 32'h0000_0002);
    aux1 = 12'h5A5;
    wr(6'h00, 2'd0, 32'h01);
    wait_idle();
    rd(6'h20, v); chk("R4 aux1 selected", v, 32'h5A5);
    wr(6'h04, 2'd2, 32'h0000_0000);
    wr(6'h00, 2'd0, 32'h01);
    rd(6'h00, v); chk("R4 sel 00 start ignored", v, 0);
    wr(6'h04, 2'd2, 32'h0000_0003);
    wr(6'h00, 2'd0, 32'h01);
    rd(6'h00, v); chk("R4 sel 11 start ignored", v, 0);

    // R5: battery ranges
    cur_tag = "R5";
    bat = 12'hFED;
    wr(6'h04, 2'd2, 32'h0000_0012);
    wr(6'h00, 2'd0, 32'h02);
    wait_idle();
    rd(6'h1C, v); chk("R5 low range full result", v, 32'hFED);
    wr(6'h04, 2'd2, 32'h0000_0002);
    wr(6'h00, 2'd0, 32'h02);
    wait_idle();
    rd(6'h1C, v); chk("R5 high range shifted", v, 32'h3FB);

    // R6: restart and cancel attempts while busy
    cur_tag = "R6";
    wr(6'h04, 2'd2, 32'h0000_0001);
    aux0 = 12'h111;
    wr(6'h00, 2'd0, 32'h01);
    idle(1);
    wr(6'h00, 2'd0, 32'h00);
    rd(6'h00, v); chk("R6 zero write keeps busy", v & 1, 1);
    aux0 = 12'h222;
    wr(6'h00, 2'd0, 32'h01);
    wait_idle();
    rd(6'h20, v); chk("R6 restart ignored", v, 32'h111);

    // R7: power-down
    cur_tag = "R7";
    wr(6'h00, 2'd0, 32'h80);
    rd(6'h00, v); chk("R7 pd readback", v, 32'h80);
    wr(6'h00, 2'd0, 32'h83);
    rd(6'h00, v); chk("R7 start with pd set", v, 32'h80);
    wr(6'h00, 2'd0, 32'h01);
    rd(6'h00, v); chk("R7 start refused while pd was set", v, 0);
    wr(6'h00, 2'd0, 32'h01);
    rd(6'h00, v); chk("R7 start after pd cleared", v, 1);
    wait_idle();

    // R8: settling
    cur_tag = "R8";
    wr(6'h08, 2'd0, 32'hFF);
    rd(6'h0C, v); chk("R8 settling active", v, 1);
    rd(6'h08, v); chk("R1 control readback", v, 32'hFF);
    wr(6'h00, 2'd0, 32'h03);
    rd(6'h00, v); chk("R8 start refused while settling", v, 0);
    idle(SETTLE + 4);
    rd(6'h0C, v); chk("R8 settling over", v, 0);
    wr(6'h00, 2'd0, 32'h01);
    rd(6'h00, v); chk("R8 start after settling", v, 1);
    wr(6'h08, 2'd0, 32'hFF);
    rd(6'h0C, v); chk("R8 no settle while busy", v, 0);
    wait_idle();
    wr(6'h00, 2'd0, 32'h80);
    wr(6'h08, 2'd0, 32'hFF);
    rd(6'h0C, v); chk("R8 no settle while pd", v, 0);
    wr(6'h00, 2'd0, 32'h00);

    // R9: byte lanes
    cur_tag = "R9";
    wr(6'h01, 2'd0, 32'h0000_0101);
    rd(6'h00, v); chk("R9 byte at +1 ignored", v, 0);
    wr(6'h02, 2'd1, 32'h0101_0101);
    rd(6'h00, v); chk("R9 upper halfword ignored", v, 0);
    wr(6'h05, 2'd0, 32'h0000_1212);
    rd(6'h04, v); chk("R9 config byte at +1 ignored", v, 1);
    wr(6'h00, 2'd1, 32'h0000_0001);
    rd(6'h00, v); chk("R9 low halfword accepted", v, 1);
    wait_idle();

    // R1: unmapped offsets
    cur_tag = "R1";
    rd(6'h10, v); chk("R1 unmapped 0x10", v, 0);
    rd(6'h24, v); chk("R1 unmapped 0x24", v, 0);
    rd(6'h3C, v); chk("R1 unmapped 0x3C", v, 0);
    idle(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule